// File: doc/BRIEF.md
# GPIO Port with Atomic Bit-Set

An eight-pin general-purpose I/O port. Each pin has its own direction bit and data latch bit. Software reaches the direction and data registers over a small register bus. A read of the data register returns a composite byte: for an output pin it shows the latched value, and for an input pin it shows the live, synchronized pin level. The pin outputs always carry the latch. The output enables follow the direction bits.

A bit-set engine beside the register file takes a command with a bit index. It then performs a read-modify-write on the data register in three clocked phases. First it captures the composite byte, then it forces the selected bit to 1, and then it writes all eight bits back into the latch. The write-back replaces the latch bits of input pins with the pin levels that were read. That is the intended and visible effect, and software that mixes directions on one port has to allow for it. While the engine runs, bus writes to the data register are held off, so the sequence cannot be split.

Top module: `gpio_bitset_port`

## Requirements
- R1: After reset, both the direction register and the data latch hold 0x00, so `pin_oe_o` and `pin_o` are both 0x00.
- R2: `pin_oe_o` equals the direction register and `pin_o` equals the data latch, bit for bit. A direction bit of 1 marks an output and 0 marks an input.
- R3: A read request (`bus_req_i`=1, `bus_we_i`=0) raises `bus_rvalid_o` for one cycle on the following cycle. Address 0 returns the data composite and address 1 returns the direction register.
- R4: Bit n of the data composite is the latch bit when direction bit n is 1. Otherwise it is the pin level after a two-flop synchronizer, so a pin change first shows in a read requested two clock edges later.
- R5: An accepted bit-set command (`cmd_valid_i` while idle) raises `busy_o` on the next cycle. `done_o` is high in the third busy cycle. On the cycle after that the latch equals the composite captured in the first busy cycle with bit `cmd_bit_i` set.
- R6: The bit-set write-back overwrites input-pin latch bits with their sampled levels. With direction 0x3F, latch 0x80, pin 7 low and pin 6 high, setting bit 0 leaves the latch at 0x41.
- R7: A command presented while `busy_o` is high is ignored and starts no further sequence.
- R8: `bus_ready_o` is 0 for a data-register write while `busy_o` or `cmd_valid_i` is high. The write is held until ready and then lands. Direction writes are never stalled.
- R9: A bus write to the data register stores all eight bits whatever the direction, and the stored value appears on `pin_o` on the next cycle.
- R10: `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = data register, 1 = direction register |
| bus_wdata_i | input | 8 | Write data |
| bus_ready_o | output | 1 | Write accepted this cycle |
| bus_rdata_o | output | 8 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| cmd_valid_i | input | 1 | Bit-set command strobe |
| cmd_bit_i | input | 3 | Index of the bit to set |
| busy_o | output | 1 | Bit-set sequence in progress |
| done_o | output | 1 | Bit-set write-back cycle |
| pin_i | input | 8 | Pin levels |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
The hardest case to reach from the ports is contention. This means a data-register write that arrives in the middle of a bit-set, together with a second command issued while the engine is busy. The bench starts a bit-set and, on the first busy cycle, presents both a data write and an extra command. It then counts the stalled cycles and checks that the latch holds the bus value, not a mix of both. The silent overwrite of input latch bits is only visible once those pins become outputs. The bench therefore flips the direction to all outputs after a bit-set and reads the latch back through `pin_o`.

// File: rtl/gpio_bitset_pkg.sv
package gpio_bitset_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_READ   = 2'd1,
    SEQ_MODIFY = 2'd2,
    SEQ_WRITE  = 2'd3
  } seq_state_e;

  localparam logic REG_DATA = 1'b0;
  localparam logic REG_DIR  = 1'b1;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
    end
    assign pin_sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bitset_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  input  logic             bus_ready_i,
  input  logic             seq_wr_i,
  input  logic [WIDTH-1:0] seq_wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] composite_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rvalid_o
);
  logic [WIDTH-1:0] dir_q, latch_q, rdata_q;
  logic             rvalid_q;
  logic             wr_dir, wr_data, rd_req;

  assign wr_dir  = bus_req_i && bus_we_i && (bus_addr_i == REG_DIR);
  assign wr_data = bus_req_i && bus_we_i && (bus_addr_i == REG_DATA) && bus_ready_i;
  assign rd_req  = bus_req_i && !bus_we_i;

  // per-bit source select: latch for outputs, synchronized pin for inputs
  for (genvar b = 0; b < WIDTH; b++) begin : g_mux
    assign composite_o[b] = dir_q[b] ? latch_q[b] : pin_sync_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (wr_dir) begin
      dir_q <= bus_wdata_i;
    end
  end

  // sequencer write-back and bus data write are exclusive via bus_ready_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (seq_wr_i) begin
      latch_q <= seq_wdata_i;
    end else if (wr_data) begin
      latch_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= (bus_addr_i == REG_DIR) ? dir_q : composite_o;
    end
  end

  assign dir_o    = dir_q;
  assign latch_o  = latch_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/gpio_bitset_seq.sv
module gpio_bitset_seq
  import gpio_bitset_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [IDX_W-1:0] cmd_bit_i,
  input  logic [WIDTH-1:0] composite_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic [IDX_W-1:0] bit_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] bit_q;
  logic [WIDTH-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      bit_q   <= '0;
      buf_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cmd_valid_i) begin
            bit_q   <= cmd_bit_i;
            state_q <= SEQ_READ;
          end
        end
        SEQ_READ: begin
          buf_q   <= composite_i;
          state_q <= SEQ_MODIFY;
        end
        SEQ_MODIFY: begin
          buf_q[bit_q] <= 1'b1;
          state_q      <= SEQ_WRITE;
        end
        SEQ_WRITE: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = (state_q == SEQ_WRITE);
  assign wr_o    = done_o;
  assign wdata_o = buf_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/gpio_bitset_port.sv
module gpio_bitset_port
  import gpio_bitset_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic             bus_ready_o,
  output logic [WIDTH-1:0] bus_rdata_o,
  output logic             bus_rvalid_o,
  input  logic             cmd_valid_i,
  input  logic [IDX_W-1:0] cmd_bit_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  logic [WIDTH-1:0] pin_sync, dir, latch, composite, seq_wdata;
  logic             seq_wr, seq_busy;
  logic [IDX_W-1:0] seq_bit;

  // hold data writes off while a set sequence is pending or running
  assign bus_ready_o = !(bus_we_i && (bus_addr_i == REG_DATA) && (seq_busy || cmd_valid_i));

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pin_sync_o(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni,
    .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_ready_i (bus_ready_o),
    .seq_wr_i    (seq_wr),
    .seq_wdata_i (seq_wdata),
    .pin_sync_i  (pin_sync),
    .dir_o       (dir),
    .latch_o     (latch),
    .composite_o (composite),
    .rdata_o     (bus_rdata_o),
    .rvalid_o    (bus_rvalid_o)
  );

  gpio_bitset_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_bit_i,
    .composite_i (composite),
    .busy_o      (seq_busy),
    .done_o,
    .wr_o        (seq_wr),
    .wdata_o     (seq_wdata),
    .bit_o       (seq_bit)
  );

  assign busy_o   = seq_busy;
  assign pin_o    = latch;
  assign pin_oe_o = dir;
endmodule

// File: rtl/gpio_bitset_port_chk.sv
module gpio_bitset_port_chk #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic             bus_addr_i,
  input logic [WIDTH-1:0] bus_wdata_i,
  input logic             bus_ready_o,
  input logic             bus_rvalid_o,
  input logic             cmd_valid_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [IDX_W-1:0] seq_bit
);
  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_we_i && bus_addr_i |=> pin_oe_o == $past(bus_wdata_i)); // R2
  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_we_i |=> bus_rvalid_o); // R3
  AST_SET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o && !done_o); // R5
  AST_SET_BIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> pin_o[$past(seq_bit)]); // R5
  AST_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && cmd_valid_i |=> !busy_o); // R7
  AST_WR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && bus_we_i && !bus_addr_i |-> !bus_ready_o); // R8
  AST_DATA_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_we_i && !bus_addr_i && bus_ready_o |=> pin_o == $past(bus_wdata_i)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

bind gpio_bitset_port gpio_bitset_port_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
  .bus_ready_o, .bus_rvalid_o, .cmd_valid_i, .busy_o, .done_o,
  .pin_o, .pin_oe_o, .seq_bit
);

// File: tb/gpio_bitset_port_tb.sv
module gpio_bitset_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_ready, bus_rvalid;
  logic [7:0] bus_rdata;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_bit = '0;
  logic       busy, done;
  logic [7:0] pins = '0;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] m_dir = '0, m_latch = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bitset_port u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_ready_o(bus_ready), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .cmd_valid_i(cmd_valid), .cmd_bit_i(cmd_bit), .busy_o(busy), .done_o(done),
    .pin_i(pins), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] composite();
    return (m_dir & m_latch) | (~m_dir & pins);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected rvalid", 8'h01, 8'h00);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_CYCLES) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <= %0d", cycles, WD_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_read(input logic addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = addr;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic bus_write(input logic addr, input logic [7:0] data, output int stalls);
    stalls = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    #1;
    while (!bus_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (addr) m_dir = data; else m_latch = data;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic bitset(input logic [2:0] idx, input bit intrude, input string tag);
    logic [7:0] exp;
    exp = composite() | (8'h01 << idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bit = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy after accept", {7'd0, busy}, 8'h01);
    if (intrude) begin cmd_valid = 1'b1; cmd_bit = 3'd5; end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 done not early", {7'd0, done}, 8'h00);
    @(negedge clk);
    chk("R5 done in third busy cycle", {7'd0, done}, 8'h01);
    @(negedge clk);
    chk("R10 done single pulse", {7'd0, done}, 8'h00);
    chk("R5 idle after write-back", {7'd0, busy}, 8'h00);
    chk(tag, pin_out, exp);
    m_latch = exp;
  endtask

  initial begin
    int st;
    repeat (3) @(negedge clk);
    chk("R1 oe at reset", pin_oe, 8'h00);
    chk("R1 out at reset", pin_out, 8'h00);
    rst_n = 1'b1;
    bus_read(1'b1, 8'h00, "R1 dir reads 00");
    bus_read(1'b0, 8'h00, "R3 data reads pins 00");

    // R9 write with all inputs, latch still stored
    bus_write(1'b0, 8'hA5, st);
    chk("R9 latch stored with all inputs", pin_out, 8'hA5);
    chk("R2 oe stays input", pin_oe, 8'h00);
    set_pins(8'h3C);
    bus_read(1'b0, 8'h3C, "R4 inputs show pins");

    // R4 sync latency: change then read after two edges
    @(negedge clk);
    pins = 8'hC3;
    @(negedge clk);
    bus_read(1'b0, 8'hC3, "R4 pin change after two edges");

    bus_write(1'b1, 8'h0F, st);
    chk("R2 oe follows dir", pin_oe, 8'h0F);
    chk("R8 dir write not stalled", st[7:0], 8'h00);
    bus_read(1'b1, 8'h0F, "R3 dir readback");
    bus_read(1'b0, composite(), "R4 mixed composite");

    // R6 documented case
    bus_write(1'b1, 8'h3F, st);
    bus_write(1'b0, 8'h80, st);
    set_pins(8'h40);
    bus_read(1'b0, 8'h40, "R6 composite before set");
    bitset(3'd0, 1'b0, "R6 latch becomes 41");
    chk("R6 pin0 driven high", {7'd0, pin_out[0] & pin_oe[0]}, 8'h01);
    bus_write(1'b1, 8'hFF, st);
    bus_read(1'b0, 8'h41, "R6 input latch bits overwritten");

    // R5 set on an output bit with other pattern, plus R7 intrusion
    bus_write(1'b1, 8'hF0, st);
    bus_write(1'b0, 8'h00, st);
    set_pins(8'h0A);
    bitset(3'd6, 1'b1, "R5 latch 4A");
    repeat (3) @(negedge clk);
    chk("R7 no second sequence", {7'd0, busy}, 8'h00);
    chk("R7 latch unchanged", pin_out, 8'h4A);

    // R8 stalled data write during a sequence
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bit = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h11;
    #1;
    st = 0;
    while (!bus_ready) begin st++; @(negedge clk); #1; end
    chk("R8 stall cycles", st[7:0], 8'h03);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    chk("R8 held write lands after set", pin_out, 8'h11);
    m_latch = 8'h11;
    bus_read(1'b0, composite(), "R8 composite after write");

    repeat (3) @(negedge clk);
    chk("R3 all reads returned", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule